// File: doc/BRIEF.md
# Three-state snooping coherency controller for a write-back data cache

This block keeps the coherency state of every line of a direct-mapped write-back data cache. Each line is invalid, exclusive-unmodified or modified; there is no shared state. Because no line can be shared, every coherent fill goes out as read-with-intent-to-modify, and the fetching cache becomes the sole owner. The block holds its own tag/state table. It receives two kinds of event: local processor operations (load, store, flush, clean, zero-line) and snooped bus transactions. For each event it decides the new state of the addressed line and any bus operation needed.

Bus operations go out on a request/acknowledge port. The request is held until it is acknowledged. Each state-table write is reported on an update port in the cycle after it happens. The local requester holds its request until a done pulse arrives, and snoops are offered while `snp_ready` is high. A snoop that arrives while a local bus request waits makes the controller withdraw that request and serve the snoop first. The still-held local request is then evaluated again from the new state.

Top module: `mei_line_ctrl`

## Requirements
- R1: After reset every line is invalid, `bus_req`, `lcl_done` and `upd_valid` are low and `snp_ready` is high. A raised `bus_req` always carries a real operation. Encodings: line state invalid=0, exclusive=1, modified=2; bus operation none=0, read-with-intent-to-modify=1, push/write=2, write-with-kill=3, kill=4.
- R2: A load (op 0) or store (op 1) miss requests bus operation 1 at the line address (offset bits zero) in the cycle after acceptance. The request is held until `bus_ack`. In the cycle after the acknowledge, `lcl_done` pulses and the line is reported exclusive (load) or modified (store).
- R3: A load hit issues no bus operation and leaves the state as it is. A store hit on an exclusive line turns it modified with no bus operation. In both cases done and the update come in the cycle after acceptance.
- R4: A snooped cacheable read (kind 0) or write (kind 1) that hits a modified line pushes it (operation 2) and then reports it invalid. On an exclusive line it reports invalid with no bus operation.
- R5: A snooped caching-inhibited read (kind 2) that hits a modified line pushes it and leaves it exclusive. On an exclusive line it issues no bus operation and the line stays exclusive.
- R6: A flush (op 2) of a modified line issues write-with-kill and leaves it invalid. A flush of an exclusive line invalidates it with no bus operation. A flush that misses writes nothing.
- R7: A clean (op 3) of a modified line issues a write (operation 2) and leaves it exclusive. On any other state it issues no bus operation and leaves the state unchanged.
- R8: A zero-line (op 4) of an invalid line issues write-with-kill and makes it modified. On an exclusive or modified line it issues kill and makes it modified.
- R9: A snooped block kill (kind 3) that hits invalidates the line with no bus operation. Other broadcast maintenance (kind 4) and snoops that miss change no state and issue nothing.
- R10: A snoop that arrives while a local bus request is still unacknowledged withdraws that request in the next cycle. The snoop is served first, including any push, and the held local request is then evaluated again against the updated line.
- R11: A load, store or zero-line that misses on a line holding a different modified tag first pushes the old line at its own address and reports it invalid. The request is then taken again and proceeds as a miss on an invalid line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_valid | input | 1 | Local operation request, held until `lcl_done` |
| lcl_op | input | 3 | Local operation code |
| lcl_addr | input | ADDR_W | Local byte address |
| lcl_done | output | 1 | Local operation completed (one-cycle pulse) |
| snp_valid | input | 1 | Snooped transaction present, held until accepted |
| snp_kind | input | 3 | Snooped transaction kind |
| snp_addr | input | ADDR_W | Snooped byte address |
| snp_ready | output | 1 | Snoop accepted at the next edge when valid |
| bus_req | output | 1 | Bus operation request |
| bus_kind | output | 3 | Bus operation code |
| bus_addr | output | ADDR_W | Line address of the bus operation |
| bus_ack | input | 1 | Bus operation acknowledged |
| upd_valid | output | 1 | A table entry was written in the previous cycle |
| upd_index | output | IDX_W | Index of the written line |
| upd_tag | output | TAG_W | Tag of the written line |
| upd_state | output | 2 | New state of the written line |

## Verification
An event accepted at edge k shows its bus request in the cycle after k. When no bus operation is needed, the done pulse and the update appear in that same cycle instead. An acknowledge sampled at edge j produces the update, and the done pulse for a final step, in the cycle after j. A victim push is followed by the retaken request's own bus request one cycle later, and a withdrawn request drops one cycle after the snoop arrives. The bench drives and samples only on falling edges and counts exactly those cycles before each comparison. It predicts every bus operation and update from its own reference table of line states and tags.

// File: rtl/mei_pkg.sv
package mei_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_EXC = 2'd1,
    LN_MOD = 2'd2
  } line_st_e;

  typedef enum logic [2:0] {
    LOP_LOAD  = 3'd0,
    LOP_STORE = 3'd1,
    LOP_FLUSH = 3'd2,
    LOP_CLEAN = 3'd3,
    LOP_ZERO  = 3'd4
  } lop_e;

  typedef enum logic [2:0] {
    SNP_READ  = 3'd0,
    SNP_WRITE = 3'd1,
    SNP_CIRD  = 3'd2,
    SNP_KILL  = 3'd3,
    SNP_OTHER = 3'd4
  } snp_e;

  typedef enum logic [2:0] {
    BOP_NONE  = 3'd0,
    BOP_RWITM = 3'd1,
    BOP_PUSH  = 3'd2,
    BOP_WKILL = 3'd3,
    BOP_KILL  = 3'd4
  } bop_e;

  typedef struct packed {
    bop_e     op;
    line_st_e nxt;
    logic     wr;
  } verdict_t;

  // Local event: eff is the line state as seen by this address (invalid on a miss).
  function automatic verdict_t local_verdict(line_st_e eff, logic hit, lop_e op);
    verdict_t v;
    v.op  = BOP_NONE;
    v.nxt = eff;
    v.wr  = hit;
    case (op)
      LOP_LOAD: begin
        v.wr = 1'b1;
        if (eff == LN_INV) begin v.op = BOP_RWITM; v.nxt = LN_EXC; end
      end
      LOP_STORE: begin
        v.wr  = 1'b1;
        v.nxt = LN_MOD;
        if (eff == LN_INV) v.op = BOP_RWITM;
      end
      LOP_FLUSH: begin
        v.nxt = LN_INV;
        if (eff == LN_MOD) v.op = BOP_WKILL;
      end
      LOP_CLEAN: begin
        if (eff == LN_MOD) begin v.op = BOP_PUSH; v.nxt = LN_EXC; end
      end
      LOP_ZERO: begin
        v.wr  = 1'b1;
        v.nxt = LN_MOD;
        v.op  = (eff == LN_INV) ? BOP_WKILL : BOP_KILL;
      end
      default: v.wr = 1'b0;
    endcase
    return v;
  endfunction

  // Snooped event: only a hit on a valid line can change anything.
  function automatic verdict_t snoop_verdict(line_st_e eff, logic hit, snp_e kind);
    verdict_t v;
    v.op  = BOP_NONE;
    v.nxt = eff;
    v.wr  = hit && (kind != SNP_OTHER);
    case (kind)
      SNP_READ, SNP_WRITE: begin
        v.nxt = LN_INV;
        if (hit && eff == LN_MOD) v.op = BOP_PUSH;
      end
      SNP_CIRD: begin
        if (hit && eff == LN_MOD) begin v.op = BOP_PUSH; v.nxt = LN_EXC; end
      end
      SNP_KILL: v.nxt = LN_INV;
      default: v.wr = 1'b0;
    endcase
    return v;
  endfunction

  function automatic logic allocates(lop_e op);
    return (op == LOP_LOAD) || (op == LOP_STORE) || (op == LOP_ZERO);
  endfunction

endpackage

// File: rtl/mei_state_table.sv
module mei_state_table
  import mei_pkg::*;
#(
  parameter int LINES = 32,
  parameter int TAG_W = 22,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  line_st_e         wr_st,
  input  logic [IDX_W-1:0] a_idx,
  output logic [TAG_W-1:0] a_tag,
  output line_st_e         a_st,
  input  logic [IDX_W-1:0] b_idx,
  output logic [TAG_W-1:0] b_tag,
  output line_st_e         b_st
);

  logic [TAG_W-1:0] tag_q [LINES];
  line_st_e         st_q  [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q[g] <= '0;
        st_q[g]  <= LN_INV;
      end else if (we && wr_idx == IDX_W'(g)) begin
        tag_q[g] <= wr_tag;
        st_q[g]  <= wr_st;
      end
    end
  end

  assign a_tag = tag_q[a_idx];
  assign a_st  = st_q[a_idx];
  assign b_tag = tag_q[b_idx];
  assign b_st  = st_q[b_idx];

endmodule

// File: rtl/mei_line_ctrl.sv
module mei_line_ctrl
  import mei_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 32,
  parameter int LINE_BYTES = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lcl_valid,
  input  logic [2:0]        lcl_op,
  input  logic [ADDR_W-1:0] lcl_addr,
  output logic              lcl_done,
  input  logic              snp_valid,
  input  logic [2:0]        snp_kind,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_ready,
  output logic              bus_req,
  output logic [2:0]        bus_kind,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ack,
  output logic              upd_valid,
  output logic [IDX_W-1:0]  upd_index,
  output logic [TAG_W-1:0]  upd_tag,
  output logic [1:0]        upd_state
);

  typedef enum logic {CT_IDLE, CT_BUS} ctl_e;

  // Address split
  logic [IDX_W-1:0] l_idx, s_idx;
  logic [TAG_W-1:0] l_tag, s_tag;
  logic             unused_offsets;
  assign l_idx = lcl_addr[OFF_W +: IDX_W];
  assign l_tag = lcl_addr[ADDR_W-1 -: TAG_W];
  assign s_idx = snp_addr[OFF_W +: IDX_W];
  assign s_tag = snp_addr[ADDR_W-1 -: TAG_W];
  assign unused_offsets = ^{lcl_addr[OFF_W-1:0], snp_addr[OFF_W-1:0]};

  // Table
  logic             tbl_we;
  logic [IDX_W-1:0] tbl_idx;
  logic [TAG_W-1:0] tbl_tag;
  line_st_e         tbl_st;
  logic [TAG_W-1:0] l_line_tag, s_line_tag;
  line_st_e         l_line_st, s_line_st;

  mei_state_table #(.LINES(LINES), .TAG_W(TAG_W)) i_table (
    .clk(clk), .rst_n(rst_n),
    .we(tbl_we), .wr_idx(tbl_idx), .wr_tag(tbl_tag), .wr_st(tbl_st),
    .a_idx(l_idx), .a_tag(l_line_tag), .a_st(l_line_st),
    .b_idx(s_idx), .b_tag(s_line_tag), .b_st(s_line_st)
  );

  // Decisions
  logic     l_hit, s_hit, victim;
  lop_e     lop;
  snp_e     skind;
  verdict_t lv, sv;

  assign lop    = lop_e'(lcl_op);
  assign skind  = snp_e'(snp_kind);
  assign l_hit  = (l_line_st != LN_INV) && (l_line_tag == l_tag);
  assign s_hit  = (s_line_st != LN_INV) && (s_line_tag == s_tag);
  assign lv     = local_verdict(l_hit ? l_line_st : LN_INV, l_hit, lop);
  assign sv     = snoop_verdict(s_hit ? s_line_st : LN_INV, s_hit, skind);
  assign victim = !l_hit && (l_line_st == LN_MOD) && allocates(lop);

  // Control state
  ctl_e             ctl_q;
  logic [IDX_W-1:0] pend_idx;
  logic [TAG_W-1:0] pend_tag;
  line_st_e         pend_st;
  logic             pend_snoop, pend_final;
  bop_e             bop_q;
  logic [ADDR_W-1:0] baddr_q;

  // Named internal events
  logic ev_snoop_take, ev_local_take, ev_ack, ev_abort;
  assign ev_snoop_take = (ctl_q == CT_IDLE) && snp_valid;
  assign ev_local_take = (ctl_q == CT_IDLE) && !snp_valid && lcl_valid;
  assign ev_ack        = (ctl_q == CT_BUS) && bus_ack;
  assign ev_abort      = (ctl_q == CT_BUS) && !bus_ack && snp_valid && !pend_snoop;

  logic local_quick;
  assign local_quick = ev_local_take && !victim && (lv.op == BOP_NONE);

  always_comb begin
    tbl_we  = 1'b0;
    tbl_idx = pend_idx;
    tbl_tag = pend_tag;
    tbl_st  = pend_st;
    if (ev_ack) begin
      tbl_we = 1'b1;
    end else if (ev_snoop_take && sv.wr && sv.op == BOP_NONE) begin
      tbl_we = 1'b1; tbl_idx = s_idx; tbl_tag = s_tag; tbl_st = sv.nxt;
    end else if (local_quick && lv.wr) begin
      tbl_we = 1'b1; tbl_idx = l_idx; tbl_tag = l_tag; tbl_st = lv.nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q      <= CT_IDLE;
      pend_idx   <= '0;
      pend_tag   <= '0;
      pend_st    <= LN_INV;
      pend_snoop <= 1'b0;
      pend_final <= 1'b0;
      bop_q      <= BOP_NONE;
      baddr_q    <= '0;
      lcl_done   <= 1'b0;
      upd_valid  <= 1'b0;
      upd_index  <= '0;
      upd_tag    <= '0;
      upd_state  <= 2'd0;
    end else begin
      lcl_done  <= local_quick || (ev_ack && pend_final);
      upd_valid <= tbl_we;
      if (tbl_we) begin
        upd_index <= tbl_idx;
        upd_tag   <= tbl_tag;
        upd_state <= tbl_st;
      end
      if (ev_ack || ev_abort) begin
        ctl_q <= CT_IDLE;
        bop_q <= BOP_NONE;
      end else if (ev_snoop_take && sv.op != BOP_NONE) begin
        ctl_q      <= CT_BUS;
        bop_q      <= sv.op;
        baddr_q    <= {s_tag, s_idx, {OFF_W{1'b0}}};
        pend_idx   <= s_idx;
        pend_tag   <= s_tag;
        pend_st    <= sv.nxt;
        pend_snoop <= 1'b1;
        pend_final <= 1'b0;
      end else if (ev_local_take && victim) begin
        ctl_q      <= CT_BUS;
        bop_q      <= BOP_PUSH;
        baddr_q    <= {l_line_tag, l_idx, {OFF_W{1'b0}}};
        pend_idx   <= l_idx;
        pend_tag   <= l_line_tag;
        pend_st    <= LN_INV;
        pend_snoop <= 1'b0;
        pend_final <= 1'b0;
      end else if (ev_local_take && lv.op != BOP_NONE) begin
        ctl_q      <= CT_BUS;
        bop_q      <= lv.op;
        baddr_q    <= {l_tag, l_idx, {OFF_W{1'b0}}};
        pend_idx   <= l_idx;
        pend_tag   <= l_tag;
        pend_st    <= lv.nxt;
        pend_snoop <= 1'b0;
        pend_final <= 1'b1;
      end
    end
  end

  assign bus_req   = (ctl_q == CT_BUS);
  assign bus_kind  = bop_q;
  assign bus_addr  = baddr_q;
  assign snp_ready = (ctl_q == CT_IDLE);

  // Assertions
  assert_real_op_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_kind != BOP_NONE));

  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !snp_valid) |=> (bus_req && $stable(bus_addr) && $stable(bus_kind)));

  assert_done_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_done |-> $past(lcl_valid));

  assert_silent_upgrade_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_local_take && lop == LOP_STORE && l_hit && l_line_st == LN_EXC)
      |=> (!bus_req && lcl_done && upd_valid && upd_state == LN_MOD));

  assert_ci_keeps_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_snoop_take && skind == SNP_CIRD && s_hit && s_line_st == LN_EXC)
      |=> (!bus_req && upd_valid && upd_state == LN_EXC));

  assert_withdraw_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (!bus_req && !lcl_done && !upd_valid));

endmodule

// File: tb/test_mei_line_ctrl.sv
module test_mei_line_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NL = 32;
  localparam int TW = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lcl_valid = 1'b0;
  logic [2:0]    lcl_op = '0;
  logic [AW-1:0] lcl_addr = '0;
  logic          lcl_done;
  logic          snp_valid = 1'b0;
  logic [2:0]    snp_kind = '0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_ready;
  logic          bus_req;
  logic [2:0]    bus_kind;
  logic [AW-1:0] bus_addr;
  logic          bus_ack = 1'b0;
  logic          upd_valid;
  logic [4:0]    upd_index;
  logic [TW-1:0] upd_tag;
  logic [1:0]    upd_state;

  always #(CLK_PERIOD/2) clk = ~clk;

  mei_line_ctrl i_mei_line_ctrl (
    .clk(clk), .rst_n(rst_n),
    .lcl_valid(lcl_valid), .lcl_op(lcl_op), .lcl_addr(lcl_addr), .lcl_done(lcl_done),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr), .snp_ready(snp_ready),
    .bus_req(bus_req), .bus_kind(bus_kind), .bus_addr(bus_addr), .bus_ack(bus_ack),
    .upd_valid(upd_valid), .upd_index(upd_index), .upd_tag(upd_tag), .upd_state(upd_state)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // Reference table: 0 invalid, 1 exclusive, 2 modified
  int          rs [NL];
  logic [TW-1:0] rt [NL];

  function automatic logic [AW-1:0] mk(input logic [TW-1:0] tg, input int ix);
    return {tg, ix[4:0], 5'b00000};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic chk_bus(input int kind, input logic [AW-1:0] ad, input string rq);
    chk(bus_req == 1'b1, rq, "bus_req", bus_req, 1);
    chk(bus_kind == kind[2:0], rq, "bus_kind", bus_kind, kind);
    chk(bus_addr == ad, rq, "bus_addr", bus_addr, ad);
  endtask

  task automatic chk_upd(input bit wr, input int ix, input logic [TW-1:0] tg,
                         input int s, input string rq);
    chk(upd_valid == wr, rq, "upd_valid", upd_valid, wr);
    if (wr) begin
      chk(upd_index == ix[4:0], rq, "upd_index", upd_index, ix);
      chk(upd_tag == tg, rq, "upd_tag", upd_tag, tg);
      chk(upd_state == s[1:0], rq, "upd_state", upd_state, s);
    end
  endtask

  task automatic ack_once();
    bus_ack = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0;
  endtask

  // Expected local outcome: op code, effective state -> bus op, next state, write
  task automatic ref_local(input int op, input int eff, input bit hit,
                           output int k, output int nx, output bit wr);
    k = 0; nx = eff; wr = 1;
    if (op == 0) begin
      if (eff == 0) begin k = 1; nx = 1; end
    end else if (op == 1) begin
      nx = 2; if (eff == 0) k = 1;
    end else if (op == 2) begin
      nx = 0; wr = hit; if (eff == 2) k = 3;
    end else if (op == 3) begin
      wr = hit; if (eff == 2) begin k = 2; nx = 1; end
    end else begin
      nx = 2; k = (eff == 0) ? 3 : 4;
    end
  endtask

  task automatic local_op(input int op, input logic [TW-1:0] tg, input int ix, input string rq);
    bit hit, vic, wr;
    int k, nx;
    hit = (rs[ix] != 0) && (rt[ix] == tg);
    vic = !hit && rs[ix] == 2 && (op == 0 || op == 1 || op == 4);
    @(negedge clk);
    lcl_valid = 1'b1; lcl_op = op[2:0]; lcl_addr = mk(tg, ix) | 32'h13;
    @(negedge clk);
    if (vic) begin
      chk_bus(2, mk(rt[ix], ix), "R11");
      ack_once();
      chk(lcl_done == 1'b0, "R11", "lcl_done after victim", lcl_done, 0);
      chk_upd(1, ix, rt[ix], 0, "R11");
      rs[ix] = 0;
      @(negedge clk);
    end
    ref_local(op, hit ? rs[ix] : 0, hit, k, nx, wr);
    if (k != 0) begin
      chk_bus(k, mk(tg, ix), rq);
      ack_once();
    end else begin
      chk(bus_req == 1'b0, rq, "bus_req idle", bus_req, 0);
    end
    chk(lcl_done == 1'b1, rq, "lcl_done", lcl_done, 1);
    chk_upd(wr, ix, tg, nx, rq);
    if (wr) begin rs[ix] = nx; rt[ix] = tg; end
    lcl_valid = 1'b0;
  endtask

  task automatic snoop_op(input int kind, input logic [TW-1:0] tg, input int ix, input string rq);
    bit hit, wr;
    int k, nx;
    hit = (rs[ix] != 0) && (rt[ix] == tg);
    wr = hit && kind != 4;
    k = 0; nx = rs[ix];
    if (hit) begin
      if (kind == 0 || kind == 1) begin nx = 0; if (rs[ix] == 2) k = 2; end
      else if (kind == 2) begin if (rs[ix] == 2) begin k = 2; nx = 1; end end
      else if (kind == 3) nx = 0;
    end
    @(negedge clk);
    snp_valid = 1'b1; snp_kind = kind[2:0]; snp_addr = mk(tg, ix) | 32'h4;
    @(negedge clk);
    snp_valid = 1'b0;
    if (k != 0) begin
      chk_bus(k, mk(tg, ix), rq);
      ack_once();
    end else begin
      chk(bus_req == 1'b0, rq, "bus_req idle", bus_req, 0);
    end
    chk(lcl_done == 1'b0, rq, "lcl_done quiet", lcl_done, 0);
    chk_upd(wr, ix, tg, nx, rq);
    if (wr) rs[ix] = nx;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(bus_req == 1'b0, "R1", "bus_req", bus_req, 0);
    chk(lcl_done == 1'b0, "R1", "lcl_done", lcl_done, 0);
    chk(upd_valid == 1'b0, "R1", "upd_valid", upd_valid, 0);
    chk(snp_ready == 1'b1, "R1", "snp_ready", snp_ready, 1);
  endtask

  task automatic t_fill();
    local_op(0, 22'h5, 1, "R2");
    local_op(1, 22'h5, 2, "R2");
  endtask

  task automatic t_hits();
    local_op(0, 22'h5, 1, "R3");
    local_op(1, 22'h5, 1, "R3");
    local_op(0, 22'h5, 1, "R3");
  endtask

  task automatic t_snoop_cacheable();
    snoop_op(0, 22'h5, 1, "R4");
    local_op(0, 22'h5, 3, "R2");
    snoop_op(1, 22'h5, 3, "R4");
    local_op(1, 22'h6, 8, "R2");
    snoop_op(1, 22'h6, 8, "R4");
  endtask

  task automatic t_ci_read();
    local_op(1, 22'h7, 4, "R2");
    snoop_op(2, 22'h7, 4, "R5");
    snoop_op(2, 22'h7, 4, "R5");
  endtask

  task automatic t_flush();
    local_op(2, 22'h7, 4, "R6");
    local_op(1, 22'h7, 4, "R2");
    local_op(2, 22'h7, 4, "R6");
    local_op(2, 22'h3, 9, "R6");
  endtask

  task automatic t_clean();
    local_op(1, 22'h8, 5, "R2");
    local_op(3, 22'h8, 5, "R7");
    local_op(3, 22'h8, 5, "R7");
  endtask

  task automatic t_zero();
    local_op(4, 22'h9, 6, "R8");
    local_op(0, 22'h9, 7, "R2");
    local_op(4, 22'h9, 7, "R8");
  endtask

  task automatic t_kill_other();
    snoop_op(3, 22'h9, 7, "R9");
    snoop_op(4, 22'h9, 6, "R9");
    snoop_op(0, 22'h1, 6, "R9");
    local_op(0, 22'h9, 6, "R9");
  endtask

  task automatic t_victim();
    local_op(0, 22'hA, 6, "R11");
    local_op(1, 22'hB, 10, "R2");
    local_op(4, 22'hC, 10, "R11");
  endtask

  // Pending kill for a zero-line is withdrawn by a snoop read to the same modified line
  task automatic t_priority();
    logic [TW-1:0] tg;
    tg = 22'h2D;
    local_op(1, tg, 12, "R2");
    @(negedge clk);
    lcl_valid = 1'b1; lcl_op = 3'd4; lcl_addr = mk(tg, 12);
    @(negedge clk);
    chk_bus(4, mk(tg, 12), "R10");
    snp_valid = 1'b1; snp_kind = 3'd0; snp_addr = mk(tg, 12);
    @(negedge clk);
    chk(bus_req == 1'b0, "R10", "withdrawn bus_req", bus_req, 0);
    chk(lcl_done == 1'b0, "R10", "lcl_done", lcl_done, 0);
    @(negedge clk);
    snp_valid = 1'b0;
    chk_bus(2, mk(tg, 12), "R10");
    ack_once();
    chk_upd(1, 12, tg, 0, "R10");
    chk(lcl_done == 1'b0, "R10", "lcl_done after push", lcl_done, 0);
    @(negedge clk);
    chk_bus(3, mk(tg, 12), "R10");
    ack_once();
    chk(lcl_done == 1'b1, "R10", "lcl_done retried", lcl_done, 1);
    chk_upd(1, 12, tg, 2, "R10");
    lcl_valid = 1'b0;
    rs[12] = 2; rt[12] = tg;
  endtask

  task automatic t_sweep();
    for (int i = 16; i < NL; i++) local_op(i % 2, 22'h30 + 22'(i), i, "R2");
    for (int i = 16; i < NL; i++) snoop_op(i % 3, 22'h30 + 22'(i), i, "R4");
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin rs[i] = 0; rt[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_hits();
    t_snoop_cacheable();
    t_ci_read();
    t_flush();
    t_clean();
    t_zero();
    t_kill_other();
    t_victim();
    t_priority();
    t_sweep();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule